// File: doc/BRIEF.md
# Challenge-Response Statistics Sequencer

This block exercises a challenge-response device, such as a delay-based physically unclonable function, and gathers statistics on its answers without help from software. It sends 16-bit challenges over a valid/ready handshake and takes one 8-bit response for each challenge it issues. A start pulse selects one of two test programs, clears every total and begins the run.

In repeatability mode the block draws challenges from a linear feedback shift register and applies each challenge several times in a row. The first answer to a challenge becomes its reference. Every later answer adds its count of differing bits, and a count of differing words, to the totals. In sensitivity mode the block walks a Gray-code sequence, so each challenge differs from the one before it in a single bit. It sums the Hamming distance between each response and the one before it. The totals stay on the outputs. A done flag marks the end of the run, and the host computes any ratios.

Top module: `puf_char_seq`

## Requirements
- R1: While `chal_valid` is high, and after that until the response is accepted, `chal_data` holds its value. Exactly one response is accepted per challenge, in the first cycle after the challenge handshake in which `rsp_valid` is high. `rsp_valid` is ignored whenever no challenge is outstanding, including in the cycle of the challenge handshake itself.
- R2: When `mode`=0 (repeatability), the challenges come from a 16-bit LFSR. It is loaded at start with `seed`, or with 16'h0001 when `seed` is zero. Each step is `{s[14:0], s[15]^s[13]^s[12]^s[10]}`, and the register steps only after the last repetition of a challenge.
- R3: In repeatability mode each of 128 challenges is applied 32 times. Repetition 0 stores the reference. Every later repetition adds popcount(response XOR reference) to `bit_err`, and adds 1 to `word_err` when that XOR is nonzero.
- R4: When `mode`=1 (sensitivity), challenge n (n = 0..1023) equals `{6'b0, n ^ (n >> 1)}`.
- R5: In sensitivity mode the first response only loads the previous-response register. Each of the next 1023 responses adds popcount(response XOR previous) to `ham_sum`.
- R6: `done` goes high in the cycle after the last response is accepted, together with the final totals. It stays high, with `busy` and `chal_valid` low, until the next start.
- R7: A start pulse is honoured in any state. It clears all totals, takes the mode and the seed, and restarts with the first challenge. If a response arrives in the same cycle as the start pulse, the response is discarded.
- R8: The totals do not wrap. The worst case is `bit_err` = 31744, `word_err` = 3968 and `ham_sum` = 8184, and each of these is reported exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that starts a run |
| mode | input | 1 | Test program: 0 repeatability, 1 sensitivity |
| seed | input | 16 | LFSR start value, taken at start |
| chal_valid | output | 1 | Challenge offered |
| chal_ready | input | 1 | Device accepts the challenge |
| chal_data | output | 16 | Challenge word |
| rsp_valid | input | 1 | Device response present |
| rsp_data | input | 8 | Device response word |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The run has completed |
| bit_err | output | 16 | Repeatability differing-bit total |
| word_err | output | 13 | Repeatability differing-response total |
| ham_sum | output | 15 | Sensitivity adjacent Hamming-distance total |

## Verification
Two events can fall in the same cycle: a start pulse and a response. The bench provokes this by driving `start` and `rsp_valid` together on an outstanding challenge. It then checks that the totals are zero and that the first Gray challenge is offered, which shows the response was dropped. The bench also drives `rsp_valid` with junk data while a challenge waits for `chal_ready`, and in the very cycle of the challenge handshake. It judges these cases by the exact final totals, which a counted junk response would change.

// File: rtl/puf_char_pkg.sv
package puf_char_pkg;

    typedef enum logic {
        MODE_REPEAT = 1'b0,
        MODE_SENS   = 1'b1
    } test_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } seq_state_e;

    // one accepted response, as seen by the statistics unit
    typedef struct packed {
        logic       hit;
        logic       first;
        test_mode_e mode;
    } rsp_evt_t;

    // feedback taps of x^16 + x^14 + x^13 + x^11 + 1 (bit index = power - 1)
    localparam logic [15:0] LFSR16_TAPS = 16'hB400;

    function automatic logic [15:0] lfsr16_step(logic [15:0] s);
        return {s[14:0], ^(s & LFSR16_TAPS)};
    endfunction

    function automatic int unsigned popcnt(logic [31:0] v);
        int unsigned n = 0;
        for (int i = 0; i < 32; i++) n += int'(v[i]);
        return n;
    endfunction

endpackage

// File: rtl/puf_chal_gen.sv
module puf_chal_gen
    import puf_char_pkg::*;
#(
    parameter int CHAL_W = 16,
    parameter int GRAY_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CHAL_W-1:0] seed,
    input  test_mode_e        mode,
    input  logic              advance,
    output logic [CHAL_W-1:0] chal
);
    logic [CHAL_W-1:0] lfsr_q;
    logic [GRAY_W-1:0] gcnt_q;
    logic [GRAY_W-1:0] gray;

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= CHAL_W'(1);
            gcnt_q <= '0;
        end else if (load) begin
            lfsr_q <= (seed == '0) ? CHAL_W'(1) : seed;
            gcnt_q <= '0;
        end else if (advance) begin
            if (mode == MODE_REPEAT) lfsr_q <= lfsr16_step(lfsr_q);
            else                     gcnt_q <= gcnt_q + 1'b1;
        end
    end

    assign gray = gcnt_q ^ (gcnt_q >> 1);
    assign chal = (mode == MODE_SENS) ? CHAL_W'(gray) : lfsr_q;

    // R4: consecutive Gray challenges differ in one bit
    assert_gray_step_R4: assert property (@(posedge clk) disable iff (rst || load)
        (advance && mode == MODE_SENS) |=> $countones(chal ^ $past(chal)) == 1);

    // R2: an LFSR step always moves to a new challenge
    assert_lfsr_moves_R2: assert property (@(posedge clk) disable iff (rst || load)
        (advance && mode == MODE_REPEAT) |=> chal != $past(chal));
endmodule

// File: rtl/puf_stat_acc.sv
module puf_stat_acc
    import puf_char_pkg::*;
#(
    parameter int RSP_W  = 8,
    parameter int BIT_W  = 16,
    parameter int WORD_W = 13,
    parameter int HAM_W  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  rsp_evt_t          evt,
    input  logic [RSP_W-1:0]  rsp,
    output logic [BIT_W-1:0]  bit_err,
    output logic [WORD_W-1:0] word_err,
    output logic [HAM_W-1:0]  ham_sum
);
    logic [RSP_W-1:0] ref_q;
    logic [RSP_W-1:0] diff;
    int unsigned      pc;

    assign diff = rsp ^ ref_q;
    assign pc   = popcnt(32'(diff));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ref_q    <= '0;
            bit_err  <= '0;
            word_err <= '0;
            ham_sum  <= '0;
        end else if (evt.hit) begin
            if (evt.first) begin
                ref_q <= rsp;
            end else if (evt.mode == MODE_REPEAT) begin
                bit_err  <= bit_err + BIT_W'(pc);
                word_err <= word_err + WORD_W'(diff != '0);
            end else begin
                ham_sum <= ham_sum + HAM_W'(pc);
                ref_q   <= rsp;
            end
        end
    end

    // R8: totals only grow during a run
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst || clear)
        evt.hit |=> (bit_err >= $past(bit_err)) && (ham_sum >= $past(ham_sum)));

    // R3: the word total moves by at most one per response
    assert_word_step_R3: assert property (@(posedge clk) disable iff (rst || clear)
        evt.hit |=> (word_err - $past(word_err)) <= WORD_W'(1));
endmodule

// File: rtl/puf_char_seq.sv
module puf_char_seq
    import puf_char_pkg::*;
#(
    parameter int CHAL_W   = 16,
    parameter int RSP_W    = 8,
    parameter int REPEATS  = 32,
    parameter int NUM_CHAL = 128,
    parameter int NUM_GRAY = 1024,
    localparam int BIT_W   = $clog2(NUM_CHAL*(REPEATS-1)*RSP_W+1) + 1,
    localparam int WORD_W  = $clog2(NUM_CHAL*(REPEATS-1)+1) + 1,
    localparam int HAM_W   = $clog2((NUM_GRAY-1)*RSP_W+1) + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode,
    input  logic [CHAL_W-1:0] seed,
    output logic              chal_valid,
    input  logic              chal_ready,
    output logic [CHAL_W-1:0] chal_data,
    input  logic              rsp_valid,
    input  logic [RSP_W-1:0]  rsp_data,
    output logic              busy,
    output logic              done,
    output logic [BIT_W-1:0]  bit_err,
    output logic [WORD_W-1:0] word_err,
    output logic [HAM_W-1:0]  ham_sum
);
    localparam int REP_W  = $clog2(REPEATS);
    localparam int GRAY_W = $clog2(NUM_GRAY);
    localparam int ITEM_W = (GRAY_W > $clog2(NUM_CHAL)) ? GRAY_W : $clog2(NUM_CHAL);

    seq_state_e        state_q;
    test_mode_e        mode_q;
    logic [REP_W-1:0]  rep_q;
    logic [ITEM_W-1:0] item_q;
    logic              rsp_hit;
    logic              rep_last;
    logic              run_last;
    logic              advance;
    rsp_evt_t          evt;

    assign rsp_hit  = (state_q == ST_WAIT) && rsp_valid && !start;
    assign rep_last = (rep_q == REP_W'(REPEATS-1));
    assign run_last = (mode_q == MODE_REPEAT)
                    ? (rep_last && item_q == ITEM_W'(NUM_CHAL-1))
                    : (item_q == ITEM_W'(NUM_GRAY-1));
    assign advance  = rsp_hit && !run_last && ((mode_q == MODE_SENS) || rep_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_REPEAT;
            rep_q   <= '0;
            item_q  <= '0;
        end else if (start) begin
            state_q <= ST_ISSUE;
            mode_q  <= test_mode_e'(mode);
            rep_q   <= '0;
            item_q  <= '0;
        end else begin
            case (state_q)
                ST_ISSUE: if (chal_ready) state_q <= ST_WAIT;
                ST_WAIT: if (rsp_hit) begin
                    state_q <= run_last ? ST_DONE : ST_ISSUE;
                    if (mode_q == MODE_REPEAT) begin
                        rep_q <= rep_q + 1'b1;
                        if (rep_last) item_q <= item_q + 1'b1;
                    end else begin
                        item_q <= item_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign evt.hit   = rsp_hit;
    assign evt.mode  = mode_q;
    assign evt.first = (mode_q == MODE_REPEAT) ? (rep_q == '0) : (item_q == '0);

    puf_chal_gen #(.CHAL_W(CHAL_W), .GRAY_W(GRAY_W)) u_gen (
        .clk     (clk),
        .rst     (rst),
        .load    (start),
        .seed    (seed),
        .mode    (test_mode_e'(start ? mode : mode_q)),
        .advance (advance),
        .chal    (chal_data)
    );

    puf_stat_acc #(.RSP_W(RSP_W), .BIT_W(BIT_W), .WORD_W(WORD_W), .HAM_W(HAM_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .clear    (start),
        .evt      (evt),
        .rsp      (rsp_data),
        .bit_err  (bit_err),
        .word_err (word_err),
        .ham_sum  (ham_sum)
    );

    assign chal_valid = (state_q == ST_ISSUE);
    assign busy       = (state_q == ST_ISSUE) || (state_q == ST_WAIT);
    assign done       = (state_q == ST_DONE);

    // R1: challenge word held until its response is taken
    assert_chal_stable_R1: assert property (@(posedge clk) disable iff (rst || start)
        (busy && !rsp_hit) |=> $stable(chal_data));

    // R1: a challenge handshake is followed by a wait, never a second offer
    assert_one_outstanding_R1: assert property (@(posedge clk) disable iff (rst || start)
        (chal_valid && chal_ready) |=> !chal_valid);

    // R6: done holds until a new start
    assert_done_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
endmodule

// File: tb/puf_char_seq_tb.sv
module puf_char_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [15:0] seed = 16'h0;
    logic        chal_valid;
    logic        chal_ready = 1'b0;
    logic [15:0] chal_data;
    logic        rsp_valid = 1'b0;
    logic [7:0]  rsp_data = 8'h0;
    logic        busy;
    logic        done;
    logic [15:0] bit_err;
    logic [12:0] word_err;
    logic [14:0] ham_sum;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    puf_char_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .seed(seed),
        .chal_valid(chal_valid), .chal_ready(chal_ready), .chal_data(chal_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy), .done(done),
        .bit_err(bit_err), .word_err(word_err), .ham_sum(ham_sum)
    );

    function automatic logic [15:0] ref_lfsr(logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic int ones8(logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic logic [7:0] device_base(logic [15:0] c);
        return c[7:0] ^ {c[11:8], c[15:12]} ^ {c[2:0], c[15:11]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(input logic m, input logic [15:0] s);
        @(negedge clk);
        mode = m; seed = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // serve one full run; adv selects worst-case answers
    task automatic run_test(input logic m, input logic [15:0] s, input bit adv);
        logic [15:0] exp_chal;
        logic [7:0]  refr, r, d;
        int eb = 0, ew = 0, eh = 0;
        int rep = 0, item = 0, nrsp = 0, chal_bad = 0, hold_bad = 0;
        logic [15:0] held;
        int exp_rsp = m ? 1024 : 4096;
        refr = 8'h0;
        exp_chal = m ? 16'h0 : ((s == 16'h0) ? 16'h0001 : s);
        pulse_start(m, s);
        while (!done && nrsp < exp_rsp + 4) begin
            if (!chal_valid) begin
                @(negedge clk);
                continue;
            end
            if (chal_data !== exp_chal) chal_bad++;
            held = chal_data;
            if (!adv) begin
                repeat ($urandom % 3) begin
                    rsp_valid = ($urandom % 2) == 0;   // junk: no challenge outstanding
                    rsp_data  = 8'($urandom);
                    @(negedge clk);
                    if (chal_data !== held) hold_bad++;
                end
            end
            chal_ready = 1'b1;
            rsp_valid  = !adv && (($urandom % 4) == 0); // junk in handshake cycle
            rsp_data   = 8'($urandom);
            @(negedge clk);
            chal_ready = 1'b0;
            rsp_valid  = 1'b0;
            if (chal_valid !== 1'b0 || chal_data !== held) hold_bad++;
            if (!adv) repeat ($urandom % 3) begin
                @(negedge clk);
                if (chal_data !== held) hold_bad++;
            end
            if (adv) r = m ? ((item % 2) ? 8'hFF : 8'h00) : ((rep == 0) ? 8'h3C : 8'hC3);
            else begin
                r = device_base(held);
                if (($urandom % 5) == 0) r ^= 8'($urandom);
            end
            rsp_valid = 1'b1;
            rsp_data  = r;
            @(negedge clk);
            rsp_valid = 1'b0;
            nrsp++;
            if (m) begin
                if (item != 0) eh += ones8(r ^ refr);
                refr = r;
                item++;
                exp_chal = 16'(item ^ (item >> 1));
            end else begin
                if (rep == 0) refr = r;
                else begin
                    d = r ^ refr;
                    eb += ones8(d);
                    ew += int'(d != 8'h0);
                end
                rep++;
                if (rep == 32) begin
                    rep = 0;
                    item++;
                    exp_chal = ref_lfsr(exp_chal);
                end
            end
        end
        check(done === 1'b1, "R6", "done after last response", int'(done), 1);
        check(nrsp == exp_rsp, "R1", "responses accepted in run", nrsp, exp_rsp);
        check(chal_bad == 0, m ? "R4" : "R2", "challenge sequence mismatches", chal_bad, 0);
        check(hold_bad == 0, "R1", "challenge hold violations", hold_bad, 0);
        if (m) check(ham_sum == 15'(eh), adv ? "R8" : "R5", "ham_sum", int'(ham_sum), eh);
        else begin
            check(bit_err == 16'(eb), adv ? "R8" : "R3", "bit_err", int'(bit_err), eb);
            check(word_err == 13'(ew), adv ? "R8" : "R3", "word_err", int'(word_err), ew);
        end
        repeat (5) @(negedge clk);
        check(done === 1'b1 && busy === 1'b0 && chal_valid === 1'b0, "R6",
              "done held, idle outputs", int'({done, busy, chal_valid}), 4);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd583));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(chal_valid === 1'b0 && busy === 1'b0 && done === 1'b0, "R6",
              "reset outputs idle", int'({chal_valid, busy, done}), 0);
        check(bit_err == 0 && word_err == 0 && ham_sum == 0, "R7",
              "reset totals zero", int'(bit_err) + int'(ham_sum), 0);

        // R7: start and response in the same cycle
        pulse_start(1'b0, 16'h1234);
        check(chal_valid === 1'b1 && chal_data == 16'h1234, "R2",
              "first LFSR challenge is seed", int'(chal_data), 16'h1234);
        chal_ready = 1'b1;
        @(negedge clk);
        chal_ready = 1'b0;
        rsp_valid = 1'b1; rsp_data = 8'hAA;
        mode = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; rsp_valid = 1'b0;
        check(chal_valid === 1'b1 && chal_data == 16'h0000 && done === 1'b0, "R7",
              "restart offers Gray challenge 0", int'(chal_data), 0);
        check(bit_err == 0 && word_err == 0 && ham_sum == 0, "R7",
              "totals cleared, collided response dropped", int'(ham_sum), 0);

        run_test(1'b0, 16'h0000, 1'b0);       // zero seed, noisy device
        run_test(1'b1, 16'h0000, 1'b0);       // Gray sweep, noisy device
        run_test(1'b0, 16'hACE1, 1'b1);       // worst-case repeat totals
        run_test(1'b1, 16'h0000, 1'b1);       // worst-case Hamming total

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule